// File: doc/BRIEF.md
# Line Sync, Keyboard Scan and NMI I/O Port

This block is the I/O and timing half of a small home-computer gate array. It runs a free-running line timer from the CPU clock. The timer produces horizontal sync with no help from software. It also keeps a modulo-8 pixel-row index that advances once per line. A non-maskable interrupt pulse can be laid over each horizontal sync so that application code is interrupted once per line. Software switches this generator on and off with I/O writes.

I/O decoding is sparse. Each of the eight low address bits stands for one device, and an access reaches a device only when its own bit is 0 and the other seven low bits are 1. A read of the keyboard device places the upper address byte on the eight row-scan lines. It returns the five active-low column inputs together with the cassette input level. The same read also starts vertical sync. Vertical sync drives a single output pin that also serves as the cassette output bit. Any I/O write ends vertical sync and restarts the pixel-row index.

The line timer is a two-state machine. LN_SYNC lasts `SYNC_W` clocks and then goes to LN_BODY. LN_BODY runs until clock `LINE_CLKS-1` of the line and then wraps to LN_SYNC, stepping the row index. The access tracker has three states. AC_IDLE goes to AC_READ when a read strobe appears (this is a read start) or to AC_WRITE when a write strobe appears (this is a write start). AC_READ or AC_WRITE returns to AC_IDLE once its strobe is released. An access that lasts several cycles therefore counts once.

Top module: `io_sync_port`

## Requirements
- R1: After reset, `vsync_tape` is 0, `nmi_n` is 1, `row_idx` is 0 and `hsync` is 1. Clock 0 of a line is the first clock after reset.
- R2: `hsync` is high for the first `SYNC_W` (16) clocks of every line, and a line is `LINE_CLKS` (207) clocks long.
- R3: `row_idx` increases by one, modulo 8, on the clock where a line wraps to the next.
- R4: An I/O read (`iorq_n`=0, `rd_n`=0) selects the keyboard only when A0=0 and A7..A1 are all 1. While it is selected, `rd_oe`=1 and `rd_data` = {`tape_in`, 1, 1, `kbd_col_n[4:0]`}, with the columns in bits 4..0 and the cassette input in bit 7. Any other time, `rd_oe`=0 and `rd_data`=8'hFF.
- R5: During a selected keyboard read, `kbd_row_n` equals A15..A8. Any other time it is 8'hFF.
- R6: The first clock of a selected keyboard read sets `vsync_tape` to 1 from the next cycle on. A read with any other low address does not change it.
- R7: The first clock of any I/O write (`iorq_n`=0, `wr_n`=0), whatever its address, clears `vsync_tape` and sets `row_idx` to 0 from the next cycle. A clear wins over a line wrap in the same clock.
- R8: A write with A1=0 and the other low bits 1 enables the NMI generator. A write with A2=0 and the other low bits 1 disables it. While it is enabled, `nmi_n` is 0 exactly while `hsync` is 1. While it is disabled, `nmi_n` stays 1.
- R9: A strobe held for several cycles acts only on its first clock. After a long write, `row_idx` keeps stepping at each line wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | CPU address bus |
| kbd_col_n | input | 5 | Keyboard column returns, active low |
| tape_in | input | 1 | Cassette input level |
| rd_data | output | 8 | Read data toward the CPU |
| rd_oe | output | 1 | High while `rd_data` carries keyboard data |
| kbd_row_n | output | 8 | Keyboard row scan lines |
| hsync | output | 1 | Horizontal sync, active high |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| vsync_tape | output | 1 | Vertical sync, also the cassette output bit |
| row_idx | output | 3 | Pixel-row index within a character line |

## Verification
The bench uses two kinds of low address: ones with two low bits cleared, and ones that match a real device. A decoder that tests only one bit would return keyboard data or start vertical sync on the double-cleared addresses. Writes are held across a line wrap. A design that reacts to every cycle of a strobe would keep the row index stuck at 0. A write is timed to land on a line wrap to show that the clear takes priority. A timer off by one clock in either state would make the sync width or line length 15, 17, 206 or 208.

// File: rtl/iosp_pkg.sv
package iosp_pkg;

    typedef enum logic {
        LN_SYNC = 1'b0,
        LN_BODY = 1'b1
    } line_state_t;

    typedef enum logic [1:0] {
        AC_IDLE  = 2'd0,
        AC_READ  = 2'd1,
        AC_WRITE = 2'd2
    } acc_state_t;

endpackage

// File: rtl/iosp_line_timer.sv
module iosp_line_timer
    import iosp_pkg::*;
#(
    parameter int LINE_CLKS = 207,
    parameter int SYNC_W    = 16,
    parameter int ROW_BITS  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_clr,
    output logic                hsync,
    output logic [ROW_BITS-1:0] row
);
    localparam int CNT_W = $clog2(LINE_CLKS);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_W - 1);
    localparam logic [CNT_W-1:0] LINE_LAST = CNT_W'(LINE_CLKS - 1);

    line_state_t          state, state_nxt;
    logic [CNT_W-1:0]     cnt, cnt_nxt;
    logic [ROW_BITS-1:0]  row_nxt;
    logic                 wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LN_SYNC;
            cnt   <= '0;
            row   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            row   <= row_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt + 1'b1;
        wrap      = 1'b0;
        unique case (state)
            LN_SYNC: begin
                if (cnt == SYNC_LAST) state_nxt = LN_BODY;
            end
            LN_BODY: begin
                if (cnt == LINE_LAST) begin
                    state_nxt = LN_SYNC;
                    cnt_nxt   = '0;
                    wrap      = 1'b1;
                end
            end
            default: state_nxt = LN_SYNC;
        endcase
        if (row_clr)   row_nxt = '0;
        else if (wrap) row_nxt = row + 1'b1;
        else           row_nxt = row;
    end

    always_comb begin
        hsync = (state == LN_SYNC);
    end

    p_sync_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync) |-> ($past(cnt) == SYNC_LAST));

    p_line_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> ($past(cnt) == LINE_LAST && cnt == '0));

    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row != $past(row)) |-> (row == $past(row) + 1'b1 || row == '0));

endmodule

// File: rtl/iosp_decoder.sv
module iosp_decoder
    import iosp_pkg::*;
#(
    parameter int SEL_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iorq_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [SEL_BITS-1:0] addr_lo,
    output logic                rd_act,
    output logic                rd_start,
    output logic                wr_start,
    output logic [SEL_BITS-1:0] lone
);
    acc_state_t state, state_nxt;
    logic       wr_act;

    assign rd_act = !iorq_n && !rd_n;
    assign wr_act = !iorq_n && !wr_n;

    for (genvar b = 0; b < SEL_BITS; b++) begin : g_sel
        localparam logic [SEL_BITS-1:0] OWN = SEL_BITS'(1) << b;
        assign lone[b] = !addr_lo[b] && ((addr_lo | OWN) == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AC_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            AC_IDLE: begin
                if (rd_act)      state_nxt = AC_READ;
                else if (wr_act) state_nxt = AC_WRITE;
            end
            AC_READ:  if (!rd_act) state_nxt = AC_IDLE;
            AC_WRITE: if (!wr_act) state_nxt = AC_IDLE;
            default:  state_nxt = AC_IDLE;
        endcase
    end

    always_comb begin
        rd_start = (state == AC_IDLE) && rd_act;
        wr_start = (state == AC_IDLE) && !rd_act && wr_act;
    end

    p_no_dual_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_start && wr_start));

    p_single_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    p_single_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);

endmodule

// File: rtl/iosp_kbd_port.sv
module iosp_kbd_port #(
    parameter int COLS     = 5,
    parameter int TAPE_BIT = 7,
    parameter int DW       = 8
) (
    input  logic            kbd_rd,
    input  logic [DW-1:0]   addr_hi,
    input  logic [COLS-1:0] col_n,
    input  logic            tape_in,
    output logic [DW-1:0]   rd_data,
    output logic            rd_oe,
    output logic [DW-1:0]   row_n
);
    logic [DW-1:0] word;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b < COLS) begin : g_col
            assign word[b] = col_n[b];
        end else if (b == TAPE_BIT) begin : g_tape
            assign word[b] = tape_in;
        end else begin : g_pad
            assign word[b] = 1'b1;
        end
    end

    always_comb begin
        rd_oe   = kbd_rd;
        rd_data = kbd_rd ? word : '1;
        row_n   = kbd_rd ? addr_hi : '1;
    end

endmodule

// File: rtl/io_sync_port.sv
module io_sync_port
    import iosp_pkg::*;
#(
    parameter int LINE_CLKS   = 207,
    parameter int SYNC_W      = 16,
    parameter int ROW_BITS    = 3,
    parameter int COLS        = 5,
    parameter int KBD_BIT     = 0,
    parameter int NMI_ON_BIT  = 1,
    parameter int NMI_OFF_BIT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iorq_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [15:0]         addr,
    input  logic [COLS-1:0]     kbd_col_n,
    input  logic                tape_in,
    output logic [7:0]          rd_data,
    output logic                rd_oe,
    output logic [7:0]          kbd_row_n,
    output logic                hsync,
    output logic                nmi_n,
    output logic                vsync_tape,
    output logic [ROW_BITS-1:0] row_idx
);
    localparam int SEL_BITS = 8;

    logic                rd_act, rd_start, wr_start;
    logic [SEL_BITS-1:0] lone;
    logic                nmi_en;

    iosp_decoder #(.SEL_BITS(SEL_BITS)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .iorq_n   (iorq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr_lo  (addr[SEL_BITS-1:0]),
        .rd_act   (rd_act),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .lone     (lone)
    );

    iosp_line_timer #(
        .LINE_CLKS (LINE_CLKS),
        .SYNC_W    (SYNC_W),
        .ROW_BITS  (ROW_BITS)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_clr (wr_start),
        .hsync   (hsync),
        .row     (row_idx)
    );

    iosp_kbd_port #(.COLS(COLS), .TAPE_BIT(7), .DW(8)) u_kbd (
        .kbd_rd  (rd_act && lone[KBD_BIT]),
        .addr_hi (addr[15:8]),
        .col_n   (kbd_col_n),
        .tape_in (tape_in),
        .rd_data (rd_data),
        .rd_oe   (rd_oe),
        .row_n   (kbd_row_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsync_tape <= 1'b0;
            nmi_en     <= 1'b0;
        end else begin
            if (rd_start && lone[KBD_BIT]) vsync_tape <= 1'b1;
            else if (wr_start)             vsync_tape <= 1'b0;
            if (wr_start && lone[NMI_ON_BIT])       nmi_en <= 1'b1;
            else if (wr_start && lone[NMI_OFF_BIT]) nmi_en <= 1'b0;
        end
    end

    always_comb begin
        nmi_n = !(hsync && nmi_en);
    end

    p_vsync_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && lone[KBD_BIT]) |=> vsync_tape);

    p_write_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (!vsync_tape && row_idx == '0));

    p_nmi_in_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_n |-> hsync);

endmodule

// File: tb/sim_io_sync_port.sv
module sim_io_sync_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] addr = 16'hFFFF;
    logic [4:0]  kbd_col_n = 5'h1F;
    logic        tape_in = 1'b0;
    logic [7:0]  rd_data, kbd_row_n;
    logic        rd_oe, hsync, nmi_n, vsync_tape;
    logic [2:0]  row_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    io_sync_port u0 (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .kbd_col_n(kbd_col_n), .tape_in(tape_in),
        .rd_data(rd_data), .rd_oe(rd_oe), .kbd_row_n(kbd_row_n),
        .hsync(hsync), .nmi_n(nmi_n), .vsync_tape(vsync_tape), .row_idx(row_idx)
    );

    function automatic bit only_low(input logic [7:0] a, input int b);
        return (a[b] == 1'b0) && ((a | (8'd1 << b)) == 8'hFF);
    endfunction

    function automatic logic [7:0] exp_data(input logic [15:0] a, input bit rd,
                                            input logic [4:0] c, input logic t);
        if (rd && only_low(a[7:0], 0)) return {t, 2'b11, c};
        return 8'hFF;
    endfunction

    // Reference model of the requirement timing (R2, R3, R6, R7, R8)
    int   m_cnt = 0;
    int   m_row = 0;
    bit   m_vs = 0, m_nmi = 0, m_busy = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_row <= 0; m_vs <= 0; m_nmi <= 0; m_busy <= 0;
        end else begin
            bit rd, wr, rs, ws, wrp;
            rd  = !iorq_n && !rd_n;
            wr  = !iorq_n && !wr_n;
            rs  = rd && !m_busy;
            ws  = wr && !rd && !m_busy;
            wrp = (m_cnt == 206);
            m_cnt  <= wrp ? 0 : m_cnt + 1;
            m_row  <= ws ? 0 : (wrp ? (m_row + 1) % 8 : m_row);
            m_busy <= rd || wr;
            if (rs && only_low(addr[7:0], 0)) m_vs <= 1;
            else if (ws) m_vs <= 0;
            if (ws && only_low(addr[7:0], 1)) m_nmi <= 1;
            else if (ws && only_low(addr[7:0], 2)) m_nmi <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model, sampled at the falling edge
    bit mon_on = 0;
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            bit eh;
            eh = (m_cnt < 16);
            chk(hsync == eh, "R2 hsync", hsync, eh);
            chk(row_idx == 3'(m_row), "R3/R7 row_idx", row_idx, m_row);
            chk(vsync_tape == m_vs, "R6/R7 vsync_tape", vsync_tape, m_vs);
            chk(nmi_n == !(eh && m_nmi), "R8 nmi_n", nmi_n, !(eh && m_nmi));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic io_read(input logic [15:0] a, input logic [4:0] c, input logic t, input int hold);
        @(negedge clk);
        addr = a; kbd_col_n = c; tape_in = t; iorq_n = 0; rd_n = 0;
        #1;
        chk(rd_data == exp_data(a, 1, c, t), "R4 rd_data", rd_data, exp_data(a, 1, c, t));
        chk(rd_oe == only_low(a[7:0], 0), "R4 rd_oe", rd_oe, only_low(a[7:0], 0));
        chk(kbd_row_n == (only_low(a[7:0], 0) ? a[15:8] : 8'hFF), "R5 kbd_row_n",
            kbd_row_n, only_low(a[7:0], 0) ? a[15:8] : 8'hFF);
        repeat (hold) @(negedge clk);
        iorq_n = 1; rd_n = 1; addr = 16'hFFFF;
        #1;
        chk(rd_data == 8'hFF && !rd_oe && kbd_row_n == 8'hFF, "R4 idle bus",
            {rd_oe, rd_data, kbd_row_n}, {1'b0, 16'hFFFF});
    endtask

    task automatic io_write(input logic [15:0] a, input int hold);
        @(negedge clk);
        addr = a; iorq_n = 0; wr_n = 0;
        #1;
        chk(rd_data == 8'hFF && !rd_oe, "R4 write no data", rd_data, 8'hFF);
        repeat (hold) @(negedge clk);
        iorq_n = 1; wr_n = 1; addr = 16'hFFFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int rises, width, period, r0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(vsync_tape == 0, "R1 vsync_tape", vsync_tape, 0);
        chk(nmi_n == 1, "R1 nmi_n", nmi_n, 1);
        chk(row_idx == 0, "R1 row_idx", row_idx, 0);
        chk(hsync == 1, "R1 hsync", hsync, 1);
        mon_on = 1;

        // R2 sync width and line length measured at the pins
        width = 0;
        while (hsync) begin @(negedge clk); width++; end
        chk(width == 16, "R2 sync width", width, 16);
        period = width;
        while (!hsync) begin @(negedge clk); period++; end
        chk(period == 207, "R2 line length", period, 207);

        // R3 eight lines bring the row index back to its start value
        r0 = row_idx;
        rises = 0;
        while (rises < 8) begin
            @(negedge clk);
            if (hsync && row_idx != 3'(r0 + rises)) rises++;
        end
        chk(row_idx == 3'(r0), "R3 row wrap", row_idx, r0);

        // R4/R5/R6 decode corner cases
        io_read(16'hA5FC, 5'h0A, 1, 2);   // two low bits clear: not selected
        idle(1);
        chk(vsync_tape == 0, "R6 no vsync on double select", vsync_tape, 0);
        io_read(16'h3CFD, 5'h15, 0, 2);   // another device
        idle(1);
        chk(vsync_tape == 0, "R6 no vsync on other device", vsync_tape, 0);
        io_read(16'h7EFE, 5'h13, 1, 3);   // keyboard
        idle(1);
        chk(vsync_tape == 1, "R6 vsync set", vsync_tape, 1);

        // R7 any write, unselected address, ends vsync and clears row
        io_write(16'h00FF, 1);
        #1;
        chk(vsync_tape == 0, "R7 vsync cleared", vsync_tape, 0);
        chk(row_idx == 0, "R7 row cleared", row_idx, 0);
        idle(2);

        // R8 enable, observe pulse on sync, disable
        io_write(16'h12FD, 1);
        while (!hsync) @(negedge clk);
        #1;
        chk(nmi_n == 0, "R8 nmi during sync", nmi_n, 0);
        while (hsync) @(negedge clk);
        #1;
        chk(nmi_n == 1, "R8 nmi released after sync", nmi_n, 1);
        io_write(16'h34FB, 1);
        while (!hsync) @(negedge clk);
        #1;
        chk(nmi_n == 1, "R8 nmi disabled", nmi_n, 1);

        // R7 clear landing on the wrap clock wins
        while (!(m_cnt == 205)) @(negedge clk);
        io_write(16'hFFFF, 1);
        #1;
        chk(row_idx == 0, "R7 clear beats wrap", row_idx, 0);

        // R9 long write acts once; row keeps stepping
        io_write(16'h55FF, 215);
        #1;
        chk(row_idx != 0, "R9 row advanced under held write", row_idx, m_row);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op, pick, g;
            logic [15:0] a;
            op = $urandom_range(0, 2);
            pick = $urandom_range(0, 5);
            a[15:8] = 8'($urandom);
            case (pick)
                0: a[7:0] = 8'hFE;
                1: a[7:0] = 8'hFD;
                2: a[7:0] = 8'hFB;
                3: a[7:0] = 8'hFF;
                4: a[7:0] = 8'hFE & ~(8'd1 << $urandom_range(1, 7));
                default: a[7:0] = 8'($urandom);
            endcase
            if (op == 0) io_write(a, $urandom_range(1, 4));
            else io_read(a, 5'($urandom), 1'($urandom), $urandom_range(1, 4));
            g = $urandom_range(1, 20);
            idle(g);
        end

        done = 1;
        mon_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule